// File: doc/BRIEF.md
# Predicated element issue sequencer

This block takes a single parallel operation of up to XLEN elements and sends only the elements that need work to an ALU that accepts LANES element slots per cycle. A one-cycle start pulse carries the operation: its length, a predicate bitmask, a flag that inverts the mask, a flag that selects zero-writing, three base register numbers (destination and two sources) and one vectorised flag for each of those operands. Elements whose predicate bit is clear are squeezed out. The number of issue cycles therefore follows the count of enabled elements, not the operation length.

In zero-writing mode every element below the length is issued. Disabled elements are tagged so that the ALU writes zero to their destination instead of computing. Each slot carries the element number and the three register numbers for that element. An operand marked vectorised steps one register per element. A scalar operand keeps its base register. A scalar operation is an operation of length 1.

Top module: `pred_issue_seq`

## Requirements
- R1: Element i is enabled when bit i of the effective predicate is 1. Elements at or above the length are never issued. A length above XLEN is treated as XLEN.
- R2: In skip mode (zero flag 0) each enabled element is issued exactly once and no disabled element is issued. The operation takes ceil(n/LANES) issue cycles for n enabled elements.
- R3: Within and across cycles, elements go out in ascending element order starting at lane 0. Every issue cycle except the last fills all LANES slots. Unused lanes have their slot valid bit at 0.
- R4: When the invert flag is 1, the effective predicate is the bitwise complement of the mask. When it is 0, the effective predicate is the mask itself.
- R5: In zero mode (zero flag 1) every element below the length is issued in ascending order. A disabled element has its slot zero bit at 1 (write zero) and an enabled element has it at 0 (compute). In skip mode the slot zero bit is always 0.
- R6: A slot's register number for an operand is the base plus the element number, modulo 2^REG_W, when that operand's vectorised bit is set. Otherwise it is the base. The vectorised bits are: bit 0 for the destination, bit 1 for source 1, bit 2 for source 2.
- R7: Slots appear in the cycle after the clock edge that samples start. busy_o is 1 during every issue cycle. done_o is 1 for exactly one cycle, the cycle after the last issue cycle, and busy_o is 0 in that cycle.
- R8: A length of 0, or no enabled element in skip mode, issues no slot and raises done_o in the cycle after start is sampled.
- R9: A start pulse while busy_o is 1 is ignored and does not change the operation in progress.
- R10: After reset, busy_o and done_o are 0 and no slot is valid.
- R11: A scalar operation (length 1, predicate bit 0 set, no operand vectorised) issues one slot: element 0 with the three base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches an operation |
| vl_i | input | VLW | Operation length in elements |
| pred_i | input | XLEN | Predicate mask, bit i for element i |
| inv_i | input | 1 | Invert the predicate |
| zero_i | input | 1 | 1: write zero to disabled elements; 0: skip them |
| rd_i | input | REG_W | Destination base register |
| rs1_i | input | REG_W | Source 1 base register |
| rs2_i | input | REG_W | Source 2 base register |
| vec_i | input | 3 | Vectorised flags: bit 0 dest, bit 1 src1, bit 2 src2 |
| busy_o | output | 1 | An operation is being issued |
| slot_vld_o | output | LANES | Lane slot valid bits |
| slot_idx_o | output | LANES*IDXW | Element number for each lane |
| slot_rd_o | output | LANES*REG_W | Destination register for each lane |
| slot_rs1_o | output | LANES*REG_W | Source 1 register for each lane |
| slot_rs2_o | output | LANES*REG_W | Source 2 register for each lane |
| slot_zero_o | output | LANES | 1: write zero, 0: compute |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check structural rules on every cycle:
- valid lanes are packed from lane 0 and their element numbers rise strictly across lanes;
- no element number reaches the latched length;
- write-zero tags appear only in zero mode;
- every lane is full whenever elements remain;
- done_o accompanies the fall of busy_o;
- a start pulse during busy leaves the latched operation untouched.

Only the bench scenarios can show that the right elements are issued for given mask, invert and length values, the exact cycle count, the register stepping with wrap-around, and the completion timing of empty operations.

// File: rtl/pis_pkg.sv
package pis_pkg;
  // Kind of work a lane slot asks of the ALU
  typedef enum logic {
    KIND_COMPUTE = 1'b0,
    KIND_ZERO    = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/pis_mask_prep.sv
module pis_mask_prep #(
  parameter int XLEN = 16,
  parameter int VLW  = $clog2(XLEN + 1)
) (
  input  logic [VLW-1:0]  vl_i,
  input  logic [XLEN-1:0] pred_i,
  input  logic            inv_i,
  input  logic            zero_i,
  output logic [XLEN-1:0] elig_o,
  output logic [XLEN-1:0] zmask_o,
  output logic [VLW-1:0]  len_o
);
  // Length clamp: the mask width bounds the operation
  function automatic logic [VLW-1:0] clamp_len(input logic [VLW-1:0] vl);
    return (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
  endfunction

  always_comb begin
    len_o = clamp_len(vl_i);
    for (int i = 0; i < XLEN; i++) begin
      logic in_rng;
      logic en;
      in_rng     = VLW'(i) < len_o;
      en         = pred_i[i] ^ inv_i;
      elig_o[i]  = in_rng && (en || zero_i);
      zmask_o[i] = in_rng && zero_i && !en;
    end
  end
endmodule

// File: rtl/pis_lane_pick.sv
module pis_lane_pick #(
  parameter int XLEN  = 16,
  parameter int LANES = 4,
  parameter int IDXW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]            pend_i,
  output logic [LANES-1:0]           vld_o,
  output logic [LANES-1:0][IDXW-1:0] idx_o,
  output logic [XLEN-1:0]            taken_o
);
  function automatic logic [IDXW-1:0] low_idx(input logic [XLEN-1:0] m);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (m[i]) r = IDXW'(i);
    return r;
  endfunction

  logic [LANES:0][XLEN-1:0] rem;
  assign rem[0] = pend_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vld_o[l]   = |rem[l];
    assign idx_o[l]   = low_idx(rem[l]);
    assign rem[l + 1] = rem[l] & (rem[l] - XLEN'(1));
  end

  assign taken_o = pend_i & ~rem[LANES];
endmodule

// File: rtl/pis_reg_step.sv
module pis_reg_step #(
  parameter int REG_W = 5,
  parameter int IDXW  = 4
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  input  logic [IDXW-1:0]  idx_i,
  output logic [REG_W-1:0] reg_o
);
  assign reg_o = base_i + (vec_i ? REG_W'(idx_i) : '0);
endmodule

// File: rtl/pred_issue_seq.sv
module pred_issue_seq #(
  parameter int XLEN  = 16,
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int VLW  = $clog2(XLEN + 1),
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [VLW-1:0]         vl_i,
  input  logic [XLEN-1:0]        pred_i,
  input  logic                   inv_i,
  input  logic                   zero_i,
  input  logic [REG_W-1:0]       rd_i,
  input  logic [REG_W-1:0]       rs1_i,
  input  logic [REG_W-1:0]       rs2_i,
  input  logic [2:0]             vec_i,
  output logic                   busy_o,
  output logic [LANES-1:0]       slot_vld_o,
  output logic [LANES*IDXW-1:0]  slot_idx_o,
  output logic [LANES*REG_W-1:0] slot_rd_o,
  output logic [LANES*REG_W-1:0] slot_rs1_o,
  output logic [LANES*REG_W-1:0] slot_rs2_o,
  output logic [LANES-1:0]       slot_zero_o,
  output logic                   done_o
);
  import pis_pkg::*;

  // Latched operation
  logic                  busy_q, done_q, zmode_q;
  logic [XLEN-1:0]       pend_q, zmask_q;
  logic [VLW-1:0]        len_q;
  logic [2:0][REG_W-1:0] base_q;
  logic [2:0]            vec_q;

  // Named internal events
  logic [XLEN-1:0] elig, zmask, taken, pend_left;
  logic [VLW-1:0]  len;
  logic            accept, last_cycle;
  logic [LANES-1:0]           pk_vld;
  logic [LANES-1:0][IDXW-1:0] pk_idx;

  pis_mask_prep #(.XLEN(XLEN), .VLW(VLW)) u_prep (
    .vl_i(vl_i), .pred_i(pred_i), .inv_i(inv_i), .zero_i(zero_i),
    .elig_o(elig), .zmask_o(zmask), .len_o(len)
  );

  pis_lane_pick #(.XLEN(XLEN), .LANES(LANES), .IDXW(IDXW)) u_pick (
    .pend_i(pend_q), .vld_o(pk_vld), .idx_o(pk_idx), .taken_o(taken)
  );

  assign accept     = start_i && !busy_q;
  assign pend_left  = pend_q & ~taken;
  assign last_cycle = busy_q && (pend_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      zmode_q <= 1'b0;
      pend_q  <= '0;
      zmask_q <= '0;
      len_q   <= '0;
      base_q  <= '0;
      vec_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q  <= elig;
        zmask_q <= zmask;
        len_q   <= len;
        zmode_q <= zero_i;
        base_q  <= {rs2_i, rs1_i, rd_i};
        vec_q   <= vec_i;
        busy_q  <= |elig;
        done_q  <= ~|elig;
      end else if (busy_q) begin
        pend_q <= pend_left;
        if (last_cycle) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_slot
    slot_kind_e kind;
    assign kind = (pk_vld[l] && zmask_q[pk_idx[l]]) ? KIND_ZERO : KIND_COMPUTE;
    assign slot_vld_o[l]                = pk_vld[l];
    assign slot_idx_o[l*IDXW +: IDXW]   = pk_idx[l];
    assign slot_zero_o[l]               = (kind == KIND_ZERO);

    pis_reg_step #(.REG_W(REG_W), .IDXW(IDXW)) u_rd (
      .base_i(base_q[0]), .vec_i(vec_q[0]), .idx_i(pk_idx[l]),
      .reg_o(slot_rd_o[l*REG_W +: REG_W]));
    pis_reg_step #(.REG_W(REG_W), .IDXW(IDXW)) u_rs1 (
      .base_i(base_q[1]), .vec_i(vec_q[1]), .idx_i(pk_idx[l]),
      .reg_o(slot_rs1_o[l*REG_W +: REG_W]));
    pis_reg_step #(.REG_W(REG_W), .IDXW(IDXW)) u_rs2 (
      .base_i(base_q[2]), .vec_i(vec_q[2]), .idx_i(pk_idx[l]),
      .reg_o(slot_rs2_o[l*REG_W +: REG_W]));

    AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      pk_vld[l] |-> (VLW'(pk_idx[l]) < len_q)); // R1

    if (l > 0) begin : g_order
      AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pk_vld[l] |-> (pk_vld[l-1] && (pk_idx[l] > pk_idx[l-1]))); // R3
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (slot_vld_o == '0)); // R7
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld_o & (slot_vld_o + LANES'(1))) == '0); // R3
  AST_FULL_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_cycle) |-> (&slot_vld_o)); // R3
  AST_ZERO_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_zero_o) |-> zmode_q); // R5
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(len_q) && $stable(base_q) && $stable(zmode_q))); // R9
endmodule

// File: tb/pred_issue_seq_tb.sv
module pred_issue_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 16;
  localparam int LANES = 4;
  localparam int REG_W = 5;
  localparam int VLW   = $clog2(XLEN + 1);
  localparam int IDXW  = $clog2(XLEN);

  logic clk, rst_n, start, inv, zero;
  logic [VLW-1:0] vl;
  logic [XLEN-1:0] pred;
  logic [REG_W-1:0] rd, rs1, rs2;
  logic [2:0] vec;
  logic busy, done;
  logic [LANES-1:0] s_vld, s_zero;
  logic [LANES*IDXW-1:0] s_idx;
  logic [LANES*REG_W-1:0] s_rd, s_rs1, s_rs2;

  pred_issue_seq #(.XLEN(XLEN), .LANES(LANES), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vl_i(vl), .pred_i(pred),
    .inv_i(inv), .zero_i(zero), .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2),
    .vec_i(vec), .busy_o(busy), .slot_vld_o(s_vld), .slot_idx_o(s_idx),
    .slot_rd_o(s_rd), .slot_rs1_o(s_rs1), .slot_rs2_o(s_rs2),
    .slot_zero_o(s_zero), .done_o(done));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench model: ordered list of elements the operation must issue
  int exp_list[XLEN];
  bit exp_z[XLEN];
  int exp_n;

  function automatic void build(input int vlen, input logic [XLEN-1:0] m,
                                input bit iv, input bit zm);
    int eff;
    eff = (vlen > XLEN) ? XLEN : vlen;
    exp_n = 0;
    for (int e = 0; e < eff; e++) begin
      bit en;
      en = m[e] ? !iv : iv;
      if (en || zm) begin
        exp_list[exp_n] = e;
        exp_z[exp_n] = zm && !en;
        exp_n++;
      end
    end
  endfunction

  function automatic int reg_of(input int base, input bit v, input int e);
    return v ? ((base + e) % (1 << REG_W)) : base;
  endfunction

  task automatic run_op(input int vlen, input logic [XLEN-1:0] m, input bit iv,
                        input bit zm, input int b_rd, input int b_rs1,
                        input int b_rs2, input logic [2:0] vf,
                        input bit poke, input string req);
    int ncyc;
    build(vlen, m, iv, zm);
    @(negedge clk);
    vl = VLW'(vlen); pred = m; inv = iv; zero = zm;
    rd = REG_W'(b_rd); rs1 = REG_W'(b_rs1); rs2 = REG_W'(b_rs2); vec = vf;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = (exp_n + LANES - 1) / LANES;
    for (int c = 0; c < ncyc; c++) begin
      chk(busy && !done, {req, " R7"}, "busy/done in issue cycle",
          {62'd0, busy, done}, 64'b10);
      for (int l = 0; l < LANES; l++) begin
        int k;
        logic [63:0] act, exp;
        k = c * LANES + l;
        if (k < exp_n) begin
          act = {43'd0, s_vld[l], s_idx[l*IDXW +: IDXW], s_zero[l],
                 s_rd[l*REG_W +: REG_W], s_rs1[l*REG_W +: REG_W],
                 s_rs2[l*REG_W +: REG_W]};
          exp = {43'd0, 1'b1, IDXW'(exp_list[k]), exp_z[k],
                 REG_W'(reg_of(b_rd, vf[0], exp_list[k])),
                 REG_W'(reg_of(b_rs1, vf[1], exp_list[k])),
                 REG_W'(reg_of(b_rs2, vf[2], exp_list[k]))};
          chk(act == exp, {req, " R2 R3 R5 R6"}, $sformatf("cyc %0d lane %0d", c, l), act, exp);
        end else begin
          chk(!s_vld[l], {req, " R3"}, $sformatf("unused cyc %0d lane %0d", c, l),
              {63'd0, s_vld[l]}, 64'd0);
        end
      end
      if (poke && c == 0) begin
        vl = VLW'(XLEN); pred = '1; zero = 1'b1; vec = 3'b000;
        rd = '0; rs1 = '0; rs2 = '0;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done && !busy && s_vld == '0, {req, " R7 R8"}, "completion cycle",
        {59'd0, done, busy, s_vld}, {59'd0, 1'b1, 1'b0, 4'd0});
    @(negedge clk);
    chk(!done, {req, " R7"}, "done is one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; vl = '0; pred = '0; inv = 1'b0; zero = 1'b0;
    rd = '0; rs1 = '0; rs2 = '0; vec = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && s_vld == '0, "R10", "reset state",
        {58'd0, busy, done, s_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && s_vld == '0, "R10", "after reset release",
        {58'd0, busy, done, s_vld}, 64'd0);

    run_op(1, 16'h0001, 0, 0, 7, 8, 9, 3'b000, 0, "R11");
    run_op(8, 16'h00BB, 0, 0, 1, 2, 3, 3'b111, 0, "R2");
    run_op(8, 16'h00BB, 1, 0, 1, 2, 3, 3'b111, 0, "R4");
    run_op(8, 16'h00BB, 0, 1, 4, 5, 6, 3'b101, 0, "R5");
    run_op(0, 16'hFFFF, 0, 0, 0, 0, 0, 3'b111, 0, "R8");
    run_op(12, 16'hF000, 0, 0, 0, 0, 0, 3'b111, 0, "R8");
    run_op(12, 16'hF000, 0, 1, 0, 0, 0, 3'b001, 0, "R5");
    run_op(20, 16'hFFFF, 0, 0, 0, 0, 0, 3'b010, 0, "R1");
    run_op(16, 16'hFFFF, 0, 0, 30, 28, 3, 3'b011, 0, "R6");
    run_op(16, 16'h5555, 0, 0, 10, 11, 12, 3'b100, 1, "R9");

    for (int t = 0; t < 60; t++) begin
      run_op(int'($urandom_range(0, XLEN + 1)), XLEN'($urandom),
             1'($urandom), 1'($urandom),
             int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
             int'($urandom_range(0, 31)), 3'($urandom), 1'($urandom), "R1");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule